// File: doc/BRIEF.md
# Decode-Stage Hazard and Forward Select Unit

This purely combinational block sits beside the decode stage of a five-stage in-order pipeline, where conditional branches and register-indirect jumps are resolved. It compares the two source registers of the decoding instruction with the destinations of the instructions now in execute and memory. From that comparison it produces two kinds of output: a stall request and, for each operand, a 2-bit forward select.

Each operand has two selects. One steers the early comparator in decode, which branches use. The other steers the ALU input muxes in execute, which every other instruction uses. A stall holds the fetch and decode pipeline registers and puts a bubble into execute. Operands that are not used, producers that write no register, register zero and NOP slots never create a dependency. When both stages write the same register, the instruction in execute takes precedence.

The register file, the ALU and the pipeline registers are outside this block.

Top module: `hzd_unit`

## Requirements
- R1: A source whose valid bit is low, a source equal to register 0, and a producer whose write-enable is low never cause a stall or a non-zero select.
- R2: A producer whose NOP flag is set is ignored in both stages.
- R3: If the live execute destination equals the memory destination, the memory match is ignored, so the execute producer wins.
- R4: A source that matches a load in execute raises stall, and no operand is given select 01.
- R5: For a decoding branch or register jump, a match with a non-load in execute raises stall and sets that operand's decode select to 01.
- R6: For a non-branch, a match with a non-load in execute sets that operand's execute select to 01 with no stall. The select encoding is 00 for the register file, 01 for the execute result and 10 for the memory result.
- R7: For a non-branch, a memory-stage match sets the execute select to 10 with no stall, whether or not that producer is a load.
- R8: For a branch, a match with a load in memory raises stall.
- R9: For a branch, a match with a non-load in memory sets the decode select to 10 only when no stall comes from the execute stage; otherwise that select stays 00.
- R10: A branch never drives a non-zero execute select. A non-branch never drives a non-zero decode select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_dst_i | input | 5 | destination register of the execute-stage instruction |
| ex_wen_i | input | 1 | execute-stage instruction writes a register |
| ex_load_i | input | 1 | execute-stage instruction is a load |
| ex_nop_i | input | 1 | execute-stage slot holds a NOP |
| mem_dst_i | input | 5 | destination register of the memory-stage instruction |
| mem_wen_i | input | 1 | memory-stage instruction writes a register |
| mem_load_i | input | 1 | memory-stage instruction is a load |
| mem_nop_i | input | 1 | memory-stage slot holds a NOP |
| src_a_i | input | 5 | first source register of the decoding instruction |
| src_a_vld_i | input | 1 | first source is used |
| src_b_i | input | 5 | second source register of the decoding instruction |
| src_b_vld_i | input | 1 | second source is used |
| id_branch_i | input | 1 | decoding instruction is a branch or register jump |
| stall_o | output | 1 | freeze fetch/decode, bubble into execute |
| id_sel_a_o | output | 2 | decode comparator select, operand a |
| id_sel_b_o | output | 2 | decode comparator select, operand b |
| ex_sel_a_o | output | 2 | execute ALU select, operand a |
| ex_sel_b_o | output | 2 | execute ALU select, operand b |

## Verification
The case that matters most is a branch that hits in both stages in the same cycle: one operand depends on a non-load in execute and the other depends on a non-load in memory. The stall from execute must then cancel the decode forward from memory (R9). A second overlap is both stages writing the same register, which tests the execute-over-memory priority (R3). Directed cases set up each overlap on purpose. A random stream over a small register range produces many more of them, and every clock is compared with a behavioural model.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int unsigned REG_W = 5;
  parameter int unsigned N_OPND = 2;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    FWD_RF  = 2'b00,
    FWD_EX  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_operand_match.sv
module hzd_operand_match
  import hzd_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic [W-1:0] src_i,
  input  logic         src_vld_i,
  input  logic         ex_live_i,
  input  logic [W-1:0] ex_dst_i,
  input  logic         mem_live_i,
  input  logic [W-1:0] mem_dst_i,
  output logic         ex_hit_o,
  output logic         mem_hit_o
);
  logic src_live;

  always_comb begin
    src_live  = src_vld_i && (src_i != '0);
    ex_hit_o  = src_live && ex_live_i && (src_i == ex_dst_i);
    mem_hit_o = src_live && mem_live_i && (src_i == mem_dst_i);
  end

  always_comb begin
    // younger producer shadows older one
    p_one_stage_hit_r3: assert (!(ex_hit_o && mem_hit_o));
  end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
  import hzd_pkg::*;
#(
  parameter int unsigned N = N_OPND
) (
  input  logic [N-1:0] ex_hit_i,
  input  logic [N-1:0] mem_hit_i,
  input  logic         ex_load_i,
  input  logic         mem_load_i,
  input  logic         branch_i,
  output logic         ex_block_o,
  output logic         stall_o
);
  logic mem_block;

  always_comb begin
    ex_block_o = (|ex_hit_i) && (ex_load_i || branch_i);
    mem_block  = (|mem_hit_i) && mem_load_i && branch_i;
    stall_o    = ex_block_o || mem_block;
  end

  always_comb begin
    p_stall_has_cause_r4: assert (!stall_o || (|ex_hit_i) || (|mem_hit_i));
  end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
(
  input  logic     ex_hit_i,
  input  logic     mem_hit_i,
  input  logic     ex_load_i,
  input  logic     mem_load_i,
  input  logic     branch_i,
  input  logic     ex_block_i,
  output fwd_sel_e id_sel_o,
  output fwd_sel_e ex_sel_o
);
  fwd_sel_e pick;

  always_comb begin
    pick = FWD_RF;
    if (ex_hit_i && !ex_load_i)
      pick = FWD_EX;
    else if (mem_hit_i && !(branch_i && (mem_load_i || ex_block_i)))
      pick = FWD_MEM;
    id_sel_o = branch_i ? pick : FWD_RF;
    ex_sel_o = branch_i ? FWD_RF : pick;
  end

  always_comb begin
    p_one_target_r10: assert (id_sel_o == FWD_RF || ex_sel_o == FWD_RF);
  end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
(
  input  logic [4:0] ex_dst_i,
  input  logic       ex_wen_i,
  input  logic       ex_load_i,
  input  logic       ex_nop_i,
  input  logic [4:0] mem_dst_i,
  input  logic       mem_wen_i,
  input  logic       mem_load_i,
  input  logic       mem_nop_i,
  input  logic [4:0] src_a_i,
  input  logic       src_a_vld_i,
  input  logic [4:0] src_b_i,
  input  logic       src_b_vld_i,
  input  logic       id_branch_i,
  output logic       stall_o,
  output logic [1:0] id_sel_a_o,
  output logic [1:0] id_sel_b_o,
  output logic [1:0] ex_sel_a_o,
  output logic [1:0] ex_sel_b_o
);
  logic                ex_live, mem_live, ex_block;
  logic [REG_W-1:0]    src     [N_OPND];
  logic [N_OPND-1:0]   src_vld;
  logic [N_OPND-1:0]   ex_hit, mem_hit;
  fwd_sel_e            id_sel  [N_OPND];
  fwd_sel_e            ex_sel  [N_OPND];

  always_comb begin
    ex_live  = ex_wen_i && !ex_nop_i && (ex_dst_i != '0);
    mem_live = mem_wen_i && !mem_nop_i && (mem_dst_i != '0)
               && !(ex_live && (ex_dst_i == mem_dst_i));
    src[0]   = src_a_i;
    src[1]   = src_b_i;
    src_vld  = {src_b_vld_i, src_a_vld_i};
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hzd_operand_match u_match (
      .src_i      (src[g]),
      .src_vld_i  (src_vld[g]),
      .ex_live_i  (ex_live),
      .ex_dst_i   (ex_dst_i),
      .mem_live_i (mem_live),
      .mem_dst_i  (mem_dst_i),
      .ex_hit_o   (ex_hit[g]),
      .mem_hit_o  (mem_hit[g])
    );

    hzd_fwd_sel u_sel (
      .ex_hit_i   (ex_hit[g]),
      .mem_hit_i  (mem_hit[g]),
      .ex_load_i  (ex_load_i),
      .mem_load_i (mem_load_i),
      .branch_i   (id_branch_i),
      .ex_block_i (ex_block),
      .id_sel_o   (id_sel[g]),
      .ex_sel_o   (ex_sel[g])
    );
  end

  hzd_stall_ctl u_stall (
    .ex_hit_i   (ex_hit),
    .mem_hit_i  (mem_hit),
    .ex_load_i  (ex_load_i),
    .mem_load_i (mem_load_i),
    .branch_i   (id_branch_i),
    .ex_block_o (ex_block),
    .stall_o    (stall_o)
  );

  always_comb begin
    id_sel_a_o = id_sel[0];
    id_sel_b_o = id_sel[1];
    ex_sel_a_o = ex_sel[0];
    ex_sel_b_o = ex_sel[1];
  end

  always_comb begin
    p_load_ex_stall_r4: assert (!((|ex_hit) && ex_load_i) || stall_o);
    p_load_no_ex_fwd_r4: assert (!ex_load_i || (id_sel[0] != FWD_EX && id_sel[1] != FWD_EX
                                  && ex_sel[0] != FWD_EX && ex_sel[1] != FWD_EX));
    p_br_mem_fwd_r9: assert (!(ex_block && (id_sel[0] == FWD_MEM || id_sel[1] == FWD_MEM)));
    p_nonbr_no_stall_r7: assert (id_branch_i || ex_load_i || !stall_o);
  end
endmodule

// File: tb/hzd_unit_tb.sv
module hzd_unit_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] ex_dst, mem_dst, sa, sb;
  logic ex_wen, ex_ld, ex_nop, mem_wen, mem_ld, mem_nop, sa_v, sb_v, br;
  logic stall;
  logic [1:0] ida, idb, exa, exb;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  hzd_unit u_dut (
    .ex_dst_i(ex_dst), .ex_wen_i(ex_wen), .ex_load_i(ex_ld), .ex_nop_i(ex_nop),
    .mem_dst_i(mem_dst), .mem_wen_i(mem_wen), .mem_load_i(mem_ld), .mem_nop_i(mem_nop),
    .src_a_i(sa), .src_a_vld_i(sa_v), .src_b_i(sb), .src_b_vld_i(sb_v),
    .id_branch_i(br), .stall_o(stall),
    .id_sel_a_o(ida), .id_sel_b_o(idb), .ex_sel_a_o(exa), .ex_sel_b_o(exb)
  );

  // behavioural model: returns {stall, ida, idb, exa, exb} as int fields
  int m_stall, m_id[2], m_ex[2];
  task automatic model();
    int e, m, s[2];
    bit hit_e[2], hit_m[2], any_e, any_m, blk;
    e = (ex_wen && !ex_nop && ex_dst != 0) ? int'(ex_dst) : -1;
    m = (mem_wen && !mem_nop && mem_dst != 0 && int'(mem_dst) != e) ? int'(mem_dst) : -1;
    s[0] = (sa_v && sa != 0) ? int'(sa) : -2;
    s[1] = (sb_v && sb != 0) ? int'(sb) : -2;
    any_e = 0; any_m = 0;
    for (int k = 0; k < 2; k++) begin
      hit_e[k] = (s[k] == e);
      hit_m[k] = (s[k] == m);
      any_e |= hit_e[k];
      any_m |= hit_m[k];
    end
    blk = any_e && (ex_ld || br);
    m_stall = (blk || (br && any_m && mem_ld)) ? 1 : 0;
    for (int k = 0; k < 2; k++) begin
      int v;
      v = 0;
      if (hit_e[k] && !ex_ld) v = 1;
      else if (hit_m[k]) begin
        if (!br) v = 2;
        else if (!mem_ld && !blk) v = 2;
      end
      m_id[k] = br ? v : 0;
      m_ex[k] = br ? 0 : v;
    end
  endtask

  task automatic check(string req);
    model();
    n_chk++;
    if (int'(stall) !== m_stall || int'(ida) !== m_id[0] || int'(idb) !== m_id[1]
        || int'(exa) !== m_ex[0] || int'(exb) !== m_ex[1]) begin
      n_bad++;
      $display("FAIL %s: got stall=%0d id=%0d/%0d ex=%0d/%0d exp stall=%0d id=%0d/%0d ex=%0d/%0d",
               req, stall, ida, idb, exa, exb, m_stall, m_id[0], m_id[1], m_ex[0], m_ex[1]);
    end
  endtask

  task automatic expect_out(string req, int st, int i0, int i1, int e0, int e1);
    n_chk++;
    if (int'(stall) !== st || int'(ida) !== i0 || int'(idb) !== i1
        || int'(exa) !== e0 || int'(exb) !== e1) begin
      n_bad++;
      $display("FAIL %s: got stall=%0d id=%0d/%0d ex=%0d/%0d exp stall=%0d id=%0d/%0d ex=%0d/%0d",
               req, stall, ida, idb, exa, exb, st, i0, i1, e0, e1);
    end
  endtask

  task automatic idle();
    ex_dst = 0; ex_wen = 0; ex_ld = 0; ex_nop = 0;
    mem_dst = 0; mem_wen = 0; mem_ld = 0; mem_nop = 0;
    sa = 0; sa_v = 0; sb = 0; sb_v = 0; br = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    idle();
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    settle(); expect_out("R1 idle", 0, 0, 0, 0, 0);

    // R1: register zero and unused source
    ex_wen = 1; ex_dst = 0; sa = 0; sa_v = 1; ex_ld = 1; br = 1;
    settle(); expect_out("R1 reg0", 0, 0, 0, 0, 0);
    ex_dst = 7; sa = 7; sa_v = 0;
    settle(); expect_out("R1 unused src", 0, 0, 0, 0, 0);
    idle(); ex_dst = 7; sa = 7; sa_v = 1; ex_wen = 0; ex_ld = 1;
    settle(); expect_out("R1 no write", 0, 0, 0, 0, 0);

    // R2: NOP producers
    idle(); ex_dst = 4; ex_wen = 1; ex_nop = 1; ex_ld = 1; sa = 4; sa_v = 1;
    mem_dst = 5; mem_wen = 1; mem_nop = 1; sb = 5; sb_v = 1;
    settle(); expect_out("R2 nop", 0, 0, 0, 0, 0);

    // R6: non-branch execute forward
    idle(); ex_dst = 3; ex_wen = 1; sb = 3; sb_v = 1;
    settle(); expect_out("R6 ex fwd b", 0, 0, 0, 0, 1);

    // R3: shared destination, execute wins
    mem_dst = 3; mem_wen = 1; sa = 3; sa_v = 1;
    settle(); expect_out("R3 ex wins", 0, 0, 0, 1, 1);

    // R4: load in execute
    ex_ld = 1;
    settle(); expect_out("R4 load ex", 1, 0, 0, 0, 0);

    // R7: non-branch memory forward incl load
    idle(); mem_dst = 9; mem_wen = 1; mem_ld = 1; sa = 9; sa_v = 1;
    settle(); expect_out("R7 mem load fwd", 0, 0, 0, 2, 0);

    // R5: branch vs non-load in execute
    idle(); br = 1; ex_dst = 6; ex_wen = 1; sa = 6; sa_v = 1;
    settle(); expect_out("R5 br ex", 1, 1, 0, 0, 0);

    // R9: same cycle, b from memory suppressed by execute stall
    mem_dst = 8; mem_wen = 1; sb = 8; sb_v = 1;
    settle(); expect_out("R9 br blocked", 1, 1, 0, 0, 0);

    // R9/R10: branch memory forward without stall
    ex_wen = 0;
    settle(); expect_out("R9 br mem fwd", 0, 0, 2, 0, 0);

    // R8: branch vs load in memory
    mem_ld = 1;
    settle(); expect_out("R8 br mem load", 1, 0, 0, 0, 0);

    // R10: branch on load in execute, no selects
    idle(); br = 1; ex_dst = 2; ex_wen = 1; ex_ld = 1; sa = 2; sa_v = 1;
    settle(); expect_out("R10 br ex load", 1, 0, 0, 0, 0);

    // random stream, small register range to provoke overlap
    for (int i = 0; i < 4000; i++) begin
      ex_dst = 5'($urandom_range(0, 3)); mem_dst = 5'($urandom_range(0, 3));
      sa = 5'($urandom_range(0, 3)); sb = 5'($urandom_range(0, 3));
      ex_wen = 1'($urandom); mem_wen = 1'($urandom);
      ex_ld = 1'($urandom); mem_ld = 1'($urandom);
      ex_nop = ($urandom_range(0, 7) == 0); mem_nop = ($urandom_range(0, 7) == 0);
      sa_v = ($urandom_range(0, 5) != 0); sb_v = ($urandom_range(0, 5) != 0);
      br = 1'($urandom);
      settle(); check("random model R3 R9");
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule